// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers interrupt requests from network slots and their ports into two 16-bit status words and turns them into one interrupt line toward the processor. The status bits are active-low. A bit reads 0 while its source is requesting service. Both words come out of reset as all ones.

Two strobe channels drive the status words. The raise channel pulls a bit low and the withdraw channel returns it high. Each strobe carries a slot number and a port number.

Slot 0 owns the low bank (status word A), starting at bit 0. Slots 1 to 4 share the high bank (status word B). Their bases step by four bits, so they start at bits 0, 4, 8 and 12. The port number is added to the slot's base to select the bit.

A small register bus reads the two status words. The same bus reads and writes two plain 16-bit mask words. The low byte of the first mask word leaves the block as a per-slot mask.

The bus is served by a two-state machine:
- IDLE: accepts a request.
- ACK: presents the response for one cycle.

It has two transitions:
- IDLE→ACK: taken when a request arrives.
- ACK→IDLE: taken unconditionally.

Top module: `nirq_aggregator`

## Requirements
- R1: After reset, status words A and B are 0xFFFF, `irq_o` is 0, and both mask words read 0x0000.
- R2: A raise strobe for slot 0 with port p clears bit p of status word A and leaves status word B unchanged.
- R3: A raise strobe for slot s (1 to 4) with port p clears bit 4*(s-1)+p of status word B and leaves status word A unchanged.
- R4: A withdraw strobe sets the same mapped bit back to 1 and never clears any bit.
- R5: When a raise and a withdraw strobe in the same cycle select the same bit, that bit ends up 0. When they select different bits, both take effect.
- R6: A strobe with slot above 4, or whose base plus port exceeds 15, changes neither status word.
- R7: `irq_o` is 1 exactly when, one clock earlier, either status word differed from 0xFFFF. It therefore lags a status change by one clock.
- R8: A bus request is accepted in IDLE. `bus_ack` is high for exactly one cycle, in the cycle after acceptance.
  - The bus uses byte addresses.
  - Reads of address 0x20 return status word A, and reads of 0x22 return status word B.
  - A read returns the value held at the accepting edge.
  - Reads of any unmapped address return 0x0000.
  - Write acknowledges, and every cycle without `bus_ack`, show `bus_rdata` as 0x0000.
- R9: Mask words at addresses 0x2A and 0x2C are written and read back whole.
  - `slot_mask` equals bits 7:0 of the 0x2A word.
  - Writes to 0x20, 0x22 or unmapped addresses change no register.
- R10: A request present during the ACK cycle is ignored and gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rq_v | input | 1 | Raise strobe valid |
| rq_slot | input | 3 | Raise strobe slot number |
| rq_port | input | 4 | Raise strobe port number |
| wd_v | input | 1 | Withdraw strobe valid |
| wd_slot | input | 3 | Withdraw strobe slot number |
| wd_port | input | 4 | Withdraw strobe port number |
| bus_req | input | 1 | Bus request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| stat_a | output | 16 | Status word A (slot 0) |
| stat_b | output | 16 | Status word B (slots 1 to 4) |
| irq_o | output | 1 | Combined interrupt, active high |
| slot_mask | output | 8 | Low byte of mask word at 0x2A |

## Verification
The properties assume that a strobe's slot and port are meaningful only while its valid bit is high. They also assume the bus master may hold a request across the ACK cycle and expects that request to be dropped rather than queued.

The stimulus drives every input half a clock away from the sampling edge. It keeps bus accesses and status strobes in separate cycles, so each read returns a status value the model already knows. The only request deliberately left high into an ACK cycle is the one that probes R10.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    localparam int WORD_W     = 16;
    localparam int NUM_BANKS  = 2;
    localparam int NUM_SLOTS  = 5;
    localparam int SLOT_W     = 3;
    localparam int PORT_W     = 4;
    localparam int SLOT_STEP  = 4;
    localparam int ADDR_W     = 8;
    localparam int MASK_OUT_W = 8;

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 8'h22;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 8'h2A;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 8'h2C;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/nirq_decode.sv
module nirq_decode #(
    parameter int WORD_W    = nirq_pkg::WORD_W,
    parameter int NUM_SLOTS = nirq_pkg::NUM_SLOTS,
    parameter int SLOT_W    = nirq_pkg::SLOT_W,
    parameter int PORT_W    = nirq_pkg::PORT_W,
    parameter int SLOT_STEP = nirq_pkg::SLOT_STEP
) (
    input  logic                  valid,
    input  logic [SLOT_W-1:0]     slot,
    input  logic [PORT_W-1:0]     port,
    output logic [2*WORD_W-1:0]   hit
);
    localparam int LW = 2 * WORD_W;
    localparam logic [LW-1:0] ONE = LW'(1);

    int bank;
    int base;
    int pos;

    // Slot 0 sits alone in bank A; later slots stack in bank B.
    always_comb begin
        hit  = '0;
        bank = 0;
        base = 0;
        pos  = 0;
        if (valid && (int'(slot) < NUM_SLOTS)) begin
            bank = (slot == '0) ? 0 : 1;
            base = (slot == '0) ? 0 : (int'(slot) - 1) * SLOT_STEP;
            pos  = base + int'(port);
            if (pos < WORD_W) begin
                hit = ONE << (bank * WORD_W + pos);
            end
        end
    end
endmodule

// File: rtl/nirq_status.sv
module nirq_status #(
    parameter int WORD_W    = nirq_pkg::WORD_W,
    parameter int NUM_BANKS = nirq_pkg::NUM_BANKS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0] raise_hit,
    input  logic [NUM_BANKS*WORD_W-1:0] drop_hit,
    output logic [NUM_BANKS*WORD_W-1:0] stat_q,
    output logic                        irq_q
);
    logic [NUM_BANKS-1:0] bank_quiet;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_quiet[b] = &stat_q[b*WORD_W +: WORD_W];
        end
    endgenerate

    // Withdraw first, then raise, so a raise on the same bit wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '1;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q | drop_hit) & ~raise_hit;
            irq_q  <= ~&bank_quiet;
        end
    end
endmodule

// File: rtl/nirq_bus.sv
module nirq_bus
    import nirq_pkg::*;
#(
    parameter int WORD_W     = nirq_pkg::WORD_W,
    parameter int ADDR_W     = nirq_pkg::ADDR_W,
    parameter int MASK_OUT_W = nirq_pkg::MASK_OUT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] stat_a,
    input  logic [WORD_W-1:0] stat_b,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic [MASK_OUT_W-1:0] slot_mask
);
    bus_state_e state_q;
    bus_state_e state_nx;
    logic              accept;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] mask_a_q;
    logic [WORD_W-1:0] mask_b_q;
    logic [WORD_W-1:0] rd_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = req ? ST_ACK : ST_IDLE;
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && req;

    always_comb begin
        unique case (addr)
            ADR_STAT_A: rd_sel = stat_a;
            ADR_STAT_B: rd_sel = stat_b;
            ADR_MASK_A: rd_sel = mask_a_q;
            ADR_MASK_B: rd_sel = mask_b_q;
            default:    rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
        end else if (accept) begin
            if (wr) begin
                rdata_q <= '0;
                if (addr == ADR_MASK_A) mask_a_q <= wdata;
                if (addr == ADR_MASK_B) mask_b_q <= wdata;
            end else begin
                rdata_q <= rd_sel;
            end
        end
    end

    // Output process: response only during ACK.
    always_comb begin
        ack   = (state_q == ST_ACK);
        rdata = ack ? rdata_q : '0;
    end

    assign slot_mask = mask_a_q[MASK_OUT_W-1:0];
endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator
    import nirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_v,
    input  logic [SLOT_W-1:0] rq_slot,
    input  logic [PORT_W-1:0] rq_port,
    input  logic              wd_v,
    input  logic [SLOT_W-1:0] wd_slot,
    input  logic [PORT_W-1:0] wd_port,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic [WORD_W-1:0] stat_a,
    output logic [WORD_W-1:0] stat_b,
    output logic              irq_o,
    output logic [MASK_OUT_W-1:0] slot_mask
);
    localparam int LW = NUM_BANKS * WORD_W;

    logic [1:0]             sv;
    logic [1:0][SLOT_W-1:0] ss;
    logic [1:0][PORT_W-1:0] sp;
    logic [1:0][LW-1:0]     hits;
    logic [LW-1:0]          stat_all;

    assign sv = {wd_v, rq_v};
    assign ss = {wd_slot, rq_slot};
    assign sp = {wd_port, rq_port};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_dec
            nirq_decode #(
                .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
                .PORT_W(PORT_W), .SLOT_STEP(SLOT_STEP)
            ) u_dec (
                .valid(sv[g]), .slot(ss[g]), .port(sp[g]), .hit(hits[g])
            );
        end
    endgenerate

    nirq_status #(.WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .raise_hit(hits[0]), .drop_hit(hits[1]),
        .stat_q(stat_all), .irq_q(irq_o)
    );

    assign stat_a = stat_all[WORD_W-1:0];
    assign stat_b = stat_all[2*WORD_W-1:WORD_W];

    nirq_bus #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MASK_OUT_W(MASK_OUT_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .stat_a(stat_a), .stat_b(stat_b),
        .ack(bus_ack), .rdata(bus_rdata), .slot_mask(slot_mask)
    );
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk #(
    parameter int WORD_W    = 16,
    parameter int SLOT_W    = 3,
    parameter int NUM_SLOTS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rq_v,
    input logic [SLOT_W-1:0] rq_slot,
    input logic              wd_v,
    input logic [WORD_W-1:0] stat_a,
    input logic [WORD_W-1:0] stat_b,
    input logic              irq_o,
    input logic              bus_ack,
    input logic [WORD_W-1:0] bus_rdata
);
    localparam logic [WORD_W-1:0] ONES = '1;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_a == ONES && stat_b == ONES));

    a_r2_slot0_bank_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_v && rq_slot == '0 && !wd_v) |=> $stable(stat_b));

    a_r3_upper_bank_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_v && rq_slot != '0 && int'(rq_slot) < NUM_SLOTS && !wd_v) |=> $stable(stat_a));

    a_r4_withdraw_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_v && !rq_v) |=> ((($past(stat_a) & ~stat_a) == '0) &&
                             (($past(stat_b) & ~stat_b) == '0)));

    a_r6_bad_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_v && int'(rq_slot) >= NUM_SLOTS && !wd_v) |=> ($stable(stat_a) && $stable(stat_b)));

    a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (($past(stat_a) != ONES) || ($past(stat_b) != ONES)));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));
endmodule

bind nirq_aggregator nirq_chk #(
    .WORD_W(nirq_pkg::WORD_W), .SLOT_W(nirq_pkg::SLOT_W), .NUM_SLOTS(nirq_pkg::NUM_SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rq_v(rq_v), .rq_slot(rq_slot), .wd_v(wd_v),
    .stat_a(stat_a), .stat_b(stat_b), .irq_o(irq_o),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
);

// File: tb/sim_nirq_aggregator.sv
`timescale 1ns/1ps
module sim_nirq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_v = 1'b0, wd_v = 1'b0;
    logic [2:0]  rq_slot = '0, wd_slot = '0;
    logic [3:0]  rq_port = '0, wd_port = '0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, stat_a, stat_b;
    logic        bus_ack, irq_o;
    logic [7:0]  slot_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_a = 16'hFFFF, exp_b = 16'hFFFF;
    logic [15:0] sb_val[$];
    string       sb_tag[$];

    always #10 clk = ~clk;

    nirq_aggregator u0 (
        .clk(clk), .rst_n(rst_n),
        .rq_v(rq_v), .rq_slot(rq_slot), .rq_port(rq_port),
        .wd_v(wd_v), .wd_slot(wd_slot), .wd_port(wd_port),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .stat_a(stat_a), .stat_b(stat_b), .irq_o(irq_o), .slot_mask(slot_mask)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Mapping taken from R2/R3/R6: -1 means the strobe is dropped.
    function automatic int bit_of(input int s, input int p);
        int base;
        if (s > 4) return -1;
        base = (s == 0) ? 0 : 4 * (s - 1);
        if (base + p > 15) return -1;
        return (s == 0) ? base + p : 16 + base + p;
    endfunction

    function automatic logic model_irq();
        return (exp_a != 16'hFFFF) || (exp_b != 16'hFFFF);
    endfunction

    task automatic strobe(input string tag, input bit rv, input int rs, input int rp,
                          input bit wv, input int ws, input int wp);
        logic [31:0] m;
        logic        irq_before;
        int          rb, wb;
        @(negedge clk);
        irq_before = model_irq();
        rq_v = rv; rq_slot = 3'(rs); rq_port = 4'(rp);
        wd_v = wv; wd_slot = 3'(ws); wd_port = 4'(wp);
        @(negedge clk);
        rq_v = 1'b0; wd_v = 1'b0;
        m = {exp_b, exp_a};
        wb = bit_of(ws, wp);
        rb = bit_of(rs, rp);
        if (wv && wb >= 0) m[wb] = 1'b1;
        if (rv && rb >= 0) m[rb] = 1'b0;
        exp_a = m[15:0];
        exp_b = m[31:16];
        check({tag, " stat_a"}, {16'h0, stat_a}, {16'h0, exp_a});
        check({tag, " stat_b"}, {16'h0, stat_b}, {16'h0, exp_b});
        check("R7 irq lags one clock", {31'h0, irq_o}, {31'h0, irq_before});
    endtask

    task automatic bus_op(input string tag, input bit wr, input logic [7:0] a,
                          input logic [15:0] d, input logic [15:0] exp);
        sb_val.push_back(wr ? 16'h0000 : exp);
        sb_tag.push_back(tag);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (sb_val.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected ack actual=%h expected=none", bus_rdata);
            end else begin
                check(sb_tag.pop_front(), {16'h0, bus_rdata}, {16'h0, sb_val.pop_front()});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stat_a reset", {16'h0, stat_a}, 32'h0000FFFF);
        check("R1 stat_b reset", {16'h0, stat_b}, 32'h0000FFFF);
        check("R1 irq reset", {31'h0, irq_o}, 32'h0);
        check("R1 slot_mask reset", {24'h0, slot_mask}, 32'h0);
        bus_op("R1 mask A reset", 0, 8'h2A, 16'h0, 16'h0000);
        bus_op("R1 mask B reset", 0, 8'h2C, 16'h0, 16'h0000);

        strobe("R2 slot0 port3", 1, 0, 3, 0, 0, 0);
        strobe("R3 slot2 port1", 1, 2, 1, 0, 0, 0);
        strobe("R3 slot4 port3", 1, 4, 3, 0, 0, 0);
        strobe("R3 slot1 port0", 1, 1, 0, 0, 0, 0);
        strobe("R3 slot3 port2", 1, 3, 2, 0, 0, 0);
        check("R7 irq high", {31'h0, irq_o}, 32'h1);
        bus_op("R8 read status A", 0, 8'h20, 16'h0, exp_a);
        bus_op("R8 read status B", 0, 8'h22, 16'h0, exp_b);

        strobe("R4 withdraw slot0 port3", 0, 0, 0, 1, 0, 3);
        strobe("R6 slot5 ignored", 1, 5, 0, 0, 0, 0);
        strobe("R6 slot7 ignored", 1, 7, 2, 0, 0, 0);
        strobe("R6 slot4 port4 past bit15", 1, 4, 4, 0, 0, 0);
        strobe("R6 withdraw slot6 ignored", 0, 0, 0, 1, 6, 0);
        strobe("R4 withdraw slot2 port1", 0, 0, 0, 1, 2, 1);
        strobe("R5 same bit raise wins", 1, 2, 1, 1, 2, 1);
        strobe("R5 different bits", 1, 1, 1, 1, 3, 2);
        strobe("R4 clear slot1 port0", 0, 0, 0, 1, 1, 0);
        strobe("R4 clear slot1 port1", 0, 0, 0, 1, 1, 1);
        strobe("R4 clear slot2 port1", 0, 0, 0, 1, 2, 1);
        strobe("R4 clear slot4 port3", 0, 0, 0, 1, 4, 3);
        @(negedge clk);
        check("R7 irq falls after all clear", {31'h0, irq_o}, 32'h0);

        bus_op("R9 write mask A", 1, 8'h2A, 16'h12AB, 16'h0);
        bus_op("R9 read mask A", 0, 8'h2A, 16'h0, 16'h12AB);
        check("R9 slot_mask low byte", {24'h0, slot_mask}, 32'hAB);
        bus_op("R9 write mask B", 1, 8'h2C, 16'hBEEF, 16'h0);
        bus_op("R9 read mask B", 0, 8'h2C, 16'h0, 16'hBEEF);
        bus_op("R9 write to status A", 1, 8'h20, 16'h0000, 16'h0);
        check("R9 status A unwritten", {16'h0, stat_a}, 32'h0000FFFF);
        bus_op("R8 unmapped read", 0, 8'h30, 16'h0, 16'h0000);
        bus_op("R9 unmapped write", 1, 8'h30, 16'h5555, 16'h0);
        bus_op("R9 mask A after unmapped write", 0, 8'h2A, 16'h0, 16'h12AB);
        bus_op("R9 mask B after unmapped write", 0, 8'h2C, 16'h0, 16'hBEEF);

        // R10: request held into the ACK cycle is dropped
        sb_val.push_back(16'h0000);
        sb_tag.push_back("R10 first write ack");
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 8'h2C; bus_wdata = 16'h1111;
        @(negedge clk);
        bus_wdata = 16'h2222;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        bus_op("R10 held request ignored", 0, 8'h2C, 16'h0, 16'h1111);

        repeat (2) @(negedge clk);
        check("R8 every access acknowledged", sb_val.size(), 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule